// File: doc/BRIEF.md
# Low-Power Entry and Wake-Capture Controller

This block is the decision and status core of a power manager. Software arms a low-power request by setting a hint bit in a lockable control register. When the core later reports that it is waiting for an interrupt, the controller runs a one-cycle entry check. A pending interrupt halts the attempt, and this is recorded as a fall-through. A busy nonvolatile-memory or lifecycle agent also halts it, and this is recorded as an abort. If neither occurs, the controller asserts its low-power-entry request until an enabled wake request arrives.

Wake and reset request lines are filtered through masks. Each mask has a lock bit that can only be cleared. The masked values can be read back live. From the moment a valid entry begins, the masked wake requests are ORed into a sticky wake-reason register. This continues until software sets the capture-disable bit. The two failed-entry flags sit in the same register, and software clears any bit of it by writing one.

When the controller comes back to the active state, it does three things. It clears the hint, it re-arms the control lock, and, if any wake reason is recorded, it pulses the wakeup interrupt.

Top module: `lp_ctrl`

## Requirements
- R1: After reset the register port reads as follows. Address 0 (control lock) reads 1. Address 1 (control) reads 0x40. Addresses 2 and 5 (mask locks) read 1. Addresses 3 and 6 (wake mask, reset mask) read 0. Addresses 8 (capture disable) and 9 (wake info) read 0. `lp_entry_o` and `wake_irq_o` are 0.
- R2: A write of 0 to bit 0 of address 0 clears the control lock. A write of 1 leaves it unchanged. While the lock is 0, writes to address 1 have no effect. The control fields at address 1 are: bit 0 hint, bit 4 core clock on in low power, bit 5 IO clock on in low power, bit 6 main domain kept powered.
- R3: Every return to the active state sets the control lock back to 1 and clears the hint bit. This holds for both a normal wake and a halted entry. If a software write to address 1 lands in the same cycle as the return, the hardware clear of the hint wins.
- R4: In the active state, with the hint at 1 and `core_sleeping_i` high, the controller moves to the entry check on the next edge. If that check passes, `lp_entry_o` goes high after the following edge. With the hint at 0, `core_sleeping_i` causes no entry.
- R5: Address 3 holds the 16-bit wake mask. Address 4 reads `wake_req_i` AND the mask. Address 2 is the mask's lock: writing 0 clears it, and when it is 0, writes to address 3 are ignored.
- R6: Address 6 holds the 2-bit reset mask. Address 7 reads `rst_req_i` AND the mask. Address 5 is its lock, and it behaves in the same way as the lock at address 2.
- R7: In low power, only a masked wake request ends the state. The controller then spends one cycle in a wake state and returns to active. Unmasked requests are ignored.
- R8: A passing entry check starts wake capture. From the next cycle, masked wake requests are ORed into wake-info bits 15:0 every cycle, including after the return to active. Capture stops when address 8 bit 0 is 1, and a new valid entry is needed to start it again.
- R9: If `irq_pending_i` is high during the entry check, the controller goes straight back to active, `lp_entry_o` stays 0, and wake-info bit 16 is set.
- R10: If `nvm_busy_i` is high during the entry check and `irq_pending_i` is low, the controller goes back to active and wake-info bit 17 is set. If both inputs are high, only bit 16 is set.
- R11: Writing 1 to a bit of address 9 clears that bit. A hardware set of the same bit in the same cycle wins. Nothing else clears the bits.
- R12: `wake_irq_o` is high for exactly one cycle: the first active cycle after a return, and only if some wake-info bit is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| core_sleeping_i | input | 1 | Core is waiting for an interrupt |
| irq_pending_i | input | 1 | An interrupt is pending at the core |
| nvm_busy_i | input | 1 | A flash, lifecycle or OTP transaction is in progress |
| wake_req_i | input | 16 | Wake request lines |
| rst_req_i | input | 2 | Reset request lines |
| lp_entry_o | output | 1 | Low-power entry request |
| wake_irq_o | output | 1 | Wakeup interrupt pulse |

## Verification
The bench targets the cycle where several things happen at once. One case is a software clear of a wake-info bit while a masked request keeps setting it. A design that let the clear win would drop a live wake reason. Another case is an entry check that sees both the interrupt and the busy input. A design with the priority reversed would report an abort where a fall-through belongs.

It also covers a locked control write followed by a return to active. A design that failed to re-arm the lock or clear the hint would stay unconfigurable, or would re-enter low power at once. Finally, it checks that capture continues after the return until disabled. A design that stopped capture at wake would miss reasons that arrive later.

// File: rtl/lp_ctrl_pkg.sv
package lp_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE    = 2'd0,
    ST_ENTRY_CHK = 2'd1,
    ST_LOW_PWR   = 2'd2,
    ST_WAKE      = 2'd3
  } lp_state_e;

  // register word addresses
  localparam int unsigned ADR_CTRL_LOCK = 0;
  localparam int unsigned ADR_CTRL      = 1;
  localparam int unsigned ADR_WEN_LOCK  = 2;
  localparam int unsigned ADR_WEN       = 3;
  localparam int unsigned ADR_WSTAT     = 4;
  localparam int unsigned ADR_REN_LOCK  = 5;
  localparam int unsigned ADR_REN       = 6;
  localparam int unsigned ADR_RSTAT     = 7;
  localparam int unsigned ADR_CAP_DIS   = 8;
  localparam int unsigned ADR_WINFO     = 9;

  // control field positions
  localparam int unsigned CTL_HINT      = 0;
  localparam int unsigned CTL_CORE_CLK  = 4;
  localparam int unsigned CTL_IO_CLK    = 5;
  localparam int unsigned CTL_MAIN_PWR  = 6;

endpackage

// File: rtl/lp_ctrl_fsm.sv
module lp_ctrl_fsm
  import lp_ctrl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hint_i,
  input  logic      sleeping_i,
  input  logic      irq_pending_i,
  input  logic      nvm_busy_i,
  input  logic      wake_any_i,
  output lp_state_e state_o,
  output logic      valid_entry_o,
  output logic      fall_thru_o,
  output logic      abort_o,
  output logic      return_o,
  output logic      returned_o
);

  lp_state_e state_q, state_d;
  logic      returned_q;

  always_comb begin
    state_d       = state_q;
    valid_entry_o = 1'b0;
    fall_thru_o   = 1'b0;
    abort_o       = 1'b0;
    unique case (state_q)
      ST_ACTIVE: begin
        if (hint_i && sleeping_i) state_d = ST_ENTRY_CHK;
      end
      ST_ENTRY_CHK: begin
        if (irq_pending_i) begin
          fall_thru_o = 1'b1;
          state_d     = ST_ACTIVE;
        end else if (nvm_busy_i) begin
          abort_o = 1'b1;
          state_d = ST_ACTIVE;
        end else begin
          valid_entry_o = 1'b1;
          state_d       = ST_LOW_PWR;
        end
      end
      ST_LOW_PWR: begin
        if (wake_any_i) state_d = ST_WAKE;
      end
      ST_WAKE: state_d = ST_ACTIVE;
      default: state_d = ST_ACTIVE;
    endcase
    return_o = (state_q != ST_ACTIVE) && (state_d == ST_ACTIVE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_ACTIVE;
      returned_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      returned_q <= return_o;
    end
  end

  assign state_o    = state_q;
  assign returned_o = returned_q;

  AST_CHECK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ENTRY_CHK) |=> (state_q != ST_ENTRY_CHK)); // R4
  AST_NO_ENTRY_NO_HINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && !hint_i) |=> (state_q == ST_ACTIVE)); // R4
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE) |=> (state_q == ST_ACTIVE)); // R7
  AST_FALL_THRU_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ENTRY_CHK && irq_pending_i) |=> (state_q == ST_ACTIVE)); // R9
  AST_LP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOW_PWR && !wake_any_i) |=> (state_q == ST_LOW_PWR)); // R7

endmodule

// File: rtl/lp_ctrl_regs.sv
module lp_ctrl_regs
  import lp_ctrl_pkg::*;
#(
  parameter int unsigned NUM_WAKE = 16,
  parameter int unsigned NUM_RST  = 2,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                return_i,
  output logic                ctrl_lock_o,
  output logic                hint_o,
  output logic                core_clk_o,
  output logic                io_clk_o,
  output logic                main_pwr_o,
  output logic                wen_lock_o,
  output logic [NUM_WAKE-1:0] wake_en_o,
  output logic                ren_lock_o,
  output logic [NUM_RST-1:0]  rst_en_o,
  output logic                cap_dis_o
);

  logic                ctrl_lock_q, hint_q, core_clk_q, io_clk_q, main_pwr_q;
  logic                wen_lock_q, ren_lock_q, cap_dis_q;
  logic [NUM_WAKE-1:0] wake_en_q;
  logic [NUM_RST-1:0]  rst_en_q;

  logic ctrl_lock_en, ctrl_lock_d, ctrl_en, hint_en, hint_d;
  logic wen_lock_en, wake_en_en, ren_lock_en, rst_en_en, cap_dis_en;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned target);
    return a == ADDR_W'(target);
  endfunction

  always_comb begin
    ctrl_lock_en = return_i || (we_i && hit(addr_i, ADR_CTRL_LOCK) && !wdata_i[0]);
    ctrl_lock_d  = return_i;
    ctrl_en      = we_i && hit(addr_i, ADR_CTRL) && ctrl_lock_q;
    hint_en      = ctrl_en || return_i;
    hint_d       = return_i ? 1'b0 : wdata_i[CTL_HINT];
    wen_lock_en  = we_i && hit(addr_i, ADR_WEN_LOCK) && !wdata_i[0];
    wake_en_en   = we_i && hit(addr_i, ADR_WEN) && wen_lock_q;
    ren_lock_en  = we_i && hit(addr_i, ADR_REN_LOCK) && !wdata_i[0];
    rst_en_en    = we_i && hit(addr_i, ADR_REN) && ren_lock_q;
    cap_dis_en   = we_i && hit(addr_i, ADR_CAP_DIS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_lock_q <= 1'b1;
      hint_q      <= 1'b0;
      core_clk_q  <= 1'b0;
      io_clk_q    <= 1'b0;
      main_pwr_q  <= 1'b1;
      wen_lock_q  <= 1'b1;
      wake_en_q   <= '0;
      ren_lock_q  <= 1'b1;
      rst_en_q    <= '0;
      cap_dis_q   <= 1'b0;
    end else begin
      if (ctrl_lock_en) ctrl_lock_q <= ctrl_lock_d;
      if (hint_en)      hint_q      <= hint_d;
      if (ctrl_en) begin
        core_clk_q <= wdata_i[CTL_CORE_CLK];
        io_clk_q   <= wdata_i[CTL_IO_CLK];
        main_pwr_q <= wdata_i[CTL_MAIN_PWR];
      end
      if (wen_lock_en) wen_lock_q <= 1'b0;
      if (wake_en_en)  wake_en_q  <= wdata_i[NUM_WAKE-1:0];
      if (ren_lock_en) ren_lock_q <= 1'b0;
      if (rst_en_en)   rst_en_q   <= wdata_i[NUM_RST-1:0];
      if (cap_dis_en)  cap_dis_q  <= wdata_i[0];
    end
  end

  assign ctrl_lock_o = ctrl_lock_q;
  assign hint_o      = hint_q;
  assign core_clk_o  = core_clk_q;
  assign io_clk_o    = io_clk_q;
  assign main_pwr_o  = main_pwr_q;
  assign wen_lock_o  = wen_lock_q;
  assign wake_en_o   = wake_en_q;
  assign ren_lock_o  = ren_lock_q;
  assign rst_en_o    = rst_en_q;
  assign cap_dis_o   = cap_dis_q;

  AST_CTRL_LOCKED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_lock_q && !return_i) |=> $stable({hint_q, core_clk_q, io_clk_q, main_pwr_q})); // R2
  AST_LOCK_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    return_i |=> (ctrl_lock_q && !hint_q)); // R3
  AST_WEN_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_lock_q |=> $stable(wake_en_q)); // R5
  AST_REN_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ren_lock_q |=> $stable(rst_en_q)); // R6

endmodule

// File: rtl/lp_ctrl_wakeinfo.sv
module lp_ctrl_wakeinfo #(
  parameter int unsigned NUM_WAKE = 16,
  localparam int unsigned INFO_W  = NUM_WAKE + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_entry_i,
  input  logic                cap_dis_i,
  input  logic [NUM_WAKE-1:0] wake_masked_i,
  input  logic                fall_thru_i,
  input  logic                abort_i,
  input  logic                clr_en_i,
  input  logic [INFO_W-1:0]   clr_mask_i,
  output logic [INFO_W-1:0]   info_o
);

  logic [INFO_W-1:0] info_q, info_d, set_v, clr_v;
  logic              info_en;
  logic              cap_q, cap_en, cap_d;

  always_comb begin
    set_v   = {abort_i, fall_thru_i,
               (cap_q && !cap_dis_i) ? wake_masked_i : {NUM_WAKE{1'b0}}};
    clr_v   = clr_en_i ? clr_mask_i : '0;
    info_d  = (info_q & ~clr_v) | set_v;
    info_en = (|set_v) || (|clr_v);
    cap_en  = cap_dis_i || valid_entry_i;
    cap_d   = !cap_dis_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      info_q <= '0;
      cap_q  <= 1'b0;
    end else begin
      if (info_en) info_q <= info_d;
      if (cap_en)  cap_q  <= cap_d;
    end
  end

  assign info_o = info_q;

  AST_FALL_THRU_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_thru_i |=> info_q[NUM_WAKE]); // R9
  AST_ABORT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> info_q[NUM_WAKE+1]); // R10
  AST_STICKY_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_en_i |=> (($past(info_q) & ~info_q) == '0)); // R11
  AST_NO_CAPTURE_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_dis_i && !fall_thru_i && !abort_i) |=> ((info_q & ~$past(info_q)) == '0)); // R8

endmodule

// File: rtl/lp_ctrl.sv
module lp_ctrl
  import lp_ctrl_pkg::*;
#(
  parameter int unsigned NUM_WAKE = 16,
  parameter int unsigned NUM_RST  = 2,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic                core_sleeping_i,
  input  logic                irq_pending_i,
  input  logic                nvm_busy_i,
  input  logic [NUM_WAKE-1:0] wake_req_i,
  input  logic [NUM_RST-1:0]  rst_req_i,
  output logic                lp_entry_o,
  output logic                wake_irq_o
);

  localparam int unsigned INFO_W = NUM_WAKE + 2;

  logic                ctrl_lock, hint, core_clk, io_clk, main_pwr;
  logic                wen_lock, ren_lock, cap_dis;
  logic [NUM_WAKE-1:0] wake_en, wake_masked;
  logic [NUM_RST-1:0]  rst_en, rst_masked;
  logic [INFO_W-1:0]   info;
  lp_state_e           state;
  logic                valid_entry, fall_thru, abort_evt, ret_evt, returned;
  logic                info_clr_en;

  assign wake_masked = wake_req_i & wake_en;
  assign rst_masked  = rst_req_i & rst_en;
  assign info_clr_en = reg_we_i && (reg_addr_i == ADDR_W'(ADR_WINFO));

  lp_ctrl_regs #(
    .NUM_WAKE(NUM_WAKE), .NUM_RST(NUM_RST), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .return_i(ret_evt), .ctrl_lock_o(ctrl_lock),
    .hint_o(hint), .core_clk_o(core_clk), .io_clk_o(io_clk), .main_pwr_o(main_pwr),
    .wen_lock_o(wen_lock), .wake_en_o(wake_en), .ren_lock_o(ren_lock),
    .rst_en_o(rst_en), .cap_dis_o(cap_dis)
  );

  lp_ctrl_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .hint_i(hint), .sleeping_i(core_sleeping_i),
    .irq_pending_i(irq_pending_i), .nvm_busy_i(nvm_busy_i),
    .wake_any_i(|wake_masked), .state_o(state), .valid_entry_o(valid_entry),
    .fall_thru_o(fall_thru), .abort_o(abort_evt), .return_o(ret_evt),
    .returned_o(returned)
  );

  lp_ctrl_wakeinfo #(.NUM_WAKE(NUM_WAKE)) u_winfo (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_entry_i(valid_entry), .cap_dis_i(cap_dis),
    .wake_masked_i(wake_masked), .fall_thru_i(fall_thru), .abort_i(abort_evt),
    .clr_en_i(info_clr_en), .clr_mask_i(reg_wdata_i[INFO_W-1:0]), .info_o(info)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_W'(ADR_CTRL_LOCK): reg_rdata_o[0] = ctrl_lock;
      ADDR_W'(ADR_CTRL): begin
        reg_rdata_o[CTL_HINT]     = hint;
        reg_rdata_o[CTL_CORE_CLK] = core_clk;
        reg_rdata_o[CTL_IO_CLK]   = io_clk;
        reg_rdata_o[CTL_MAIN_PWR] = main_pwr;
      end
      ADDR_W'(ADR_WEN_LOCK):  reg_rdata_o[0] = wen_lock;
      ADDR_W'(ADR_WEN):       reg_rdata_o[NUM_WAKE-1:0] = wake_en;
      ADDR_W'(ADR_WSTAT):     reg_rdata_o[NUM_WAKE-1:0] = wake_masked;
      ADDR_W'(ADR_REN_LOCK):  reg_rdata_o[0] = ren_lock;
      ADDR_W'(ADR_REN):       reg_rdata_o[NUM_RST-1:0] = rst_en;
      ADDR_W'(ADR_RSTAT):     reg_rdata_o[NUM_RST-1:0] = rst_masked;
      ADDR_W'(ADR_CAP_DIS):   reg_rdata_o[0] = cap_dis;
      ADDR_W'(ADR_WINFO):     reg_rdata_o[INFO_W-1:0] = info;
      default:                reg_rdata_o = '0;
    endcase
  end

  assign lp_entry_o = (state == ST_LOW_PWR);
  assign wake_irq_o = (state == ST_ACTIVE) && returned && (|info);

  AST_IRQ_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_irq_o |=> !wake_irq_o); // R12
  AST_LP_AFTER_CHECK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lp_entry_o) |-> $past(state == ST_ENTRY_CHK)); // R4

endmodule

// File: tb/lp_ctrl_tb_top.sv
module lp_ctrl_tb_top;

  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sleeping = 1'b0, irq_p = 1'b0, busy = 1'b0;
  logic [15:0] wreq = '0;
  logic [1:0]  rreq = '0;
  logic        lp_entry, wake_irq;

  int n_chk = 0;
  int n_fail = 0;

  lp_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .core_sleeping_i(sleeping),
    .irq_pending_i(irq_p), .nvm_busy_i(busy), .wake_req_i(wreq),
    .rst_req_i(rreq), .lp_entry_o(lp_entry), .wake_irq_o(wake_irq)
  );

  always #(CLK_T/2) clk = ~clk;

  // behavioural reference model
  int   m_st;   // 0 active, 1 check, 2 low power, 3 wake
  bit   m_clock, m_hint, m_cclk, m_io, m_pwr, m_wlock, m_rlock, m_capdis, m_cap, m_ret;
  bit [15:0] m_wen;
  bit [1:0]  m_ren;
  bit [17:0] m_info;

  task automatic model_reset();
    m_st = 0; m_clock = 1; m_hint = 0; m_cclk = 0; m_io = 0; m_pwr = 1;
    m_wlock = 1; m_rlock = 1; m_capdis = 0; m_cap = 0; m_ret = 0;
    m_wen = 0; m_ren = 0; m_info = 0;
  endtask

  task automatic model_step();
    int nst = m_st;
    bit ft = 0, ab = 0, ve = 0, ret;
    bit [17:0] setv = 0, clrv = 0;
    case (m_st)
      0: if (m_hint && sleeping) nst = 1;
      1: if (irq_p) begin nst = 0; ft = 1; end
         else if (busy) begin nst = 0; ab = 1; end
         else begin nst = 2; ve = 1; end
      2: if ((wreq & m_wen) != 0) nst = 3;
      default: nst = 0;
    endcase
    ret = (m_st != 0) && (nst == 0);
    if (m_cap && !m_capdis) setv[15:0] = wreq & m_wen;
    setv[16] = ft; setv[17] = ab;
    if (we && addr == 9) clrv = wdata[17:0];
    m_info = (m_info & ~clrv) | setv;
    if (m_capdis) m_cap = 0; else if (ve) m_cap = 1;
    if (we) begin
      case (addr)
        0: if (!wdata[0]) m_clock = 0;
        1: if (m_clock) begin
             m_hint = wdata[0]; m_cclk = wdata[4]; m_io = wdata[5]; m_pwr = wdata[6];
           end
        2: if (!wdata[0]) m_wlock = 0;
        3: if (m_wlock) m_wen = wdata[15:0];
        5: if (!wdata[0]) m_rlock = 0;
        6: if (m_rlock) m_ren = wdata[1:0];
        8: m_capdis = wdata[0];
        default: ;
      endcase
    end
    if (ret) begin m_clock = 1; m_hint = 0; end
    m_ret = ret;
    m_st = nst;
  endtask

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    logic [31:0] v = '0;
    case (a)
      0: v[0] = m_clock;
      1: begin v[0] = m_hint; v[4] = m_cclk; v[5] = m_io; v[6] = m_pwr; end
      2: v[0] = m_wlock;
      3: v[15:0] = m_wen;
      4: v[15:0] = wreq & m_wen;
      5: v[0] = m_rlock;
      6: v[1:0] = m_ren;
      7: v[1:0] = rreq & m_ren;
      8: v[0] = m_capdis;
      9: v[17:0] = m_info;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      0, 1: return "R2";
      2, 3, 4: return "R5";
      5, 6, 7: return "R6";
      8: return "R8";
      9: return "R11";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (rst_n) begin
      model_step();
      #1;
      chk("R4 lp_entry", 32'(lp_entry), 32'(m_st == 2));
      chk("R12 wake_irq", 32'(wake_irq), 32'((m_st == 0) && m_ret && (m_info != 0)));
      chk(tag_of(addr), rdata, model_rd(addr));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string req);
    @(negedge clk); addr = 4'(a); #1;
    chk(req, rdata, exp);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1..all actual=hung expected=finished");
    summary();
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    // R1 reset values
    rd(0, 32'h1, "R1"); rd(1, 32'h40, "R1"); rd(2, 32'h1, "R1"); rd(3, 32'h0, "R1");
    rd(5, 32'h1, "R1"); rd(6, 32'h0, "R1"); rd(8, 32'h0, "R1"); rd(9, 32'h0, "R1");
    chk("R1 lp_entry", 32'(lp_entry), 32'h0);

    // R4: no entry while the hint is 0
    sleeping = 1'b1; cycles(4);
    chk("R4 no hint", 32'(lp_entry), 32'h0);
    sleeping = 1'b0;

    // R2: lock write of 1 ignored, control written, then lock cleared
    wr(0, 32'h1); rd(0, 32'h1, "R2");
    wr(1, 32'h31); rd(1, 32'h31, "R2");
    wr(0, 32'h0); rd(0, 32'h0, "R2");
    wr(1, 32'h40); rd(1, 32'h31, "R2");

    // R5 wake mask
    wr(3, 32'h0005); rd(3, 32'h5, "R5");

    // R4/R7/R8/R3: full entry and wake
    @(negedge clk); sleeping = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R4 entered", 32'(lp_entry), 32'h1);
    wreq = 16'h0010; cycles(3);
    chk("R7 unmasked ignored", 32'(lp_entry), 32'h1);
    wreq = 16'h0011; @(negedge clk); @(negedge clk);
    chk("R7 back active", 32'(lp_entry), 32'h0);
    sleeping = 1'b0;
    rd(0, 32'h1, "R3"); rd(1, 32'h30, "R3");
    rd(9, 32'h1, "R8");
    // R11: clear loses against live set
    wr(9, 32'h1); rd(9, 32'h1, "R11");
    wreq = 16'h0; wr(8, 32'h1);
    wr(9, 32'h1); rd(9, 32'h0, "R11");
    wreq = 16'h0004; cycles(3); rd(9, 32'h0, "R8");
    rd(4, 32'h4, "R5");
    wreq = 16'h0;

    // R9 fall-through
    wr(1, 32'h1); irq_p = 1'b1; sleeping = 1'b1; cycles(3);
    irq_p = 1'b0; sleeping = 1'b0;
    rd(9, 32'h10000, "R9"); rd(1, 32'h0, "R3");
    wr(9, 32'h3ffff);

    // R10 abort, then both together
    wr(1, 32'h1); busy = 1'b1; sleeping = 1'b1; cycles(3);
    sleeping = 1'b0;
    rd(9, 32'h20000, "R10");
    wr(9, 32'h3ffff);
    wr(1, 32'h1); irq_p = 1'b1; sleeping = 1'b1; cycles(3);
    sleeping = 1'b0; irq_p = 1'b0; busy = 1'b0;
    rd(9, 32'h10000, "R10");
    wr(9, 32'h3ffff);

    // R8 accumulation after re-enabling capture
    wr(8, 32'h0);
    wr(1, 32'h1); sleeping = 1'b1; cycles(3);
    wreq = 16'h0001; cycles(2); sleeping = 1'b0;
    wreq = 16'h0004; cycles(2); wreq = 16'h0;
    rd(9, 32'h5, "R8");

    // R6 reset mask and lock
    wr(6, 32'h3); rreq = 2'b10; rd(7, 32'h2, "R6");
    wr(5, 32'h0); wr(6, 32'h0); rd(6, 32'h3, "R6");
    // R5 lock
    wr(2, 32'h0); wr(3, 32'h0); rd(3, 32'h5, "R5");
    rreq = 2'b00;
    cycles(4);
    summary();
  end

endmodule